// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers reset requests from six internal sources and from a shared, open-drain external reset line, and turns them into a single system reset. When any source fires, the block enters a reset sequence. It first pulls the external line low for a fixed stretch of bus cycles. It then lets the line go and waits a second fixed stretch. At the end of that wait it looks at the line again. If the line is still low, something outside is holding it, so the line is logged as a cause and the system stays in reset until the line goes high.

A read-only cause register tells start-up firmware why the last reset happened. Each cause has its own bit. A fresh sequence wipes the register before it logs new causes. A power-on request leaves only its own bit set. Requests that arrive while a sequence is already running restart the drive phase and add their bits to the register. The debug-forced request resets the system but logs no bit. Power-on and low-voltage detection happen elsewhere and reach this block as one-cycle digital pulses. All counts are in bus-clock cycles, where the bus clock runs at half the oscillator rate. The register has no write path, so nothing on the bus can change it.

Top module: `rstseq_top`

## Requirements
- R1: From idle, a pulse on any of the six request inputs, or `pinIn` read low, asserts both `sysRst` and `pinDrvEn` on the next clock cycle.
- R2: Once a sequence starts with no further requests, `pinDrvEn` stays high for exactly DRIVE_CYCLES (default 34) cycles and then drops.
- R3: `sysRst` stays high through the drive phase and through the SAMPLE_DELAY (default 38) cycles after release. If `pinIn` is high at the end of that wait, `sysRst` drops, so an undisturbed sequence keeps `sysRst` high for 72 cycles.
- R4: If `pinIn` is low at the end of the wait, status bit 0 is set and `sysRst` stays high until the first cycle in which `pinIn` reads high.
- R5: The status bits are: bit 0 external line, bit 1 power-on, bit 2 low voltage, bit 3 watchdog timeout, bit 4 illegal opcode, bit 5 illegal address. Bits 7:6 always read 0, and the debug request has no bit.
- R6: A sequence that starts from idle clears the status register and sets only the bits of the causes of that reset. A debug-only reset, or a short pulse on the line, leaves it at 0x00.
- R7: A power-on request sets the status to exactly 0x02 on the next cycle, whether it arrives from idle or in the middle of a sequence.
- R8: Any of the six request inputs seen during the drive, wait or hold phase restarts a full drive phase of DRIVE_CYCLES cycles and ORs its cause bit into the status.
- R9: While `rstN` is low, `sysRst`, `pinDrvEn` and the status are 0. Outside the events named in R4, R6, R7 and R8, the status holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset of the sequencer's own always-on domain |
| porReq | input | 1 | Power-on request pulse |
| lvdReq | input | 1 | Low-voltage request pulse |
| wdogReq | input | 1 | Watchdog timeout pulse |
| badOpReq | input | 1 | Illegal opcode pulse |
| badAddrReq | input | 1 | Illegal address pulse |
| dbgReq | input | 1 | Debug-forced reset pulse (no status bit) |
| pinIn | input | 1 | Level read back from the open-drain reset line, 1 = high |
| sysRst | output | 1 | System reset, active high |
| pinDrvEn | output | 1 | Pulls the reset line low while 1 |
| status | output | STS_W (8) | Read-only reset cause register |

## Verification
Most faults in the sequencer's state show up as a wrong length of time. If the phase counter or its terminal compare is off, the drive pulse or the reset window comes out a few cycles long or short, and this is visible at `pinDrvEn` or `sysRst` within 72 cycles of the request. A bad merge or clear path in the status logic shows only at the end of a sequence, as a wrong byte on `status`. It is caught once the sequence finishes, by comparing against a request mix whose expected bits are known. Failing to honour a late request or a held-low line stretches or shortens the reset window by tens of cycles. That is why the stimulus lands requests inside each phase and then measures the total.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_DRIVE,
    SEQ_WAIT,
    SEQ_HOLD
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart the phase counter
    logic stsFresh;  // clear status, then load new causes
    logic stsMerge;  // OR new causes into status
    logic stsPin;    // log the external line as a cause
  } seqStrobe_t;

  localparam int BIT_PIN  = 0;
  localparam int BIT_POR  = 1;
  localparam int BIT_LVD  = 2;
  localparam int BIT_WDOG = 3;
  localparam int BIT_OP   = 4;
  localparam int BIT_ADDR = 5;

endpackage

// File: rtl/rstseq_datapath.sv
`timescale 1ns/1ps
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYCLES = 34,
  parameter int SAMPLE_DELAY = 38,
  parameter int STS_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             porReq,
  input  logic             lvdReq,
  input  logic             wdogReq,
  input  logic             badOpReq,
  input  logic             badAddrReq,
  output logic             driveDone,
  output logic             waitDone,
  output logic [STS_W-1:0] status
);

  localparam int LONGEST = (DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [STS_W-1:0] POR_ONLY = STS_W'(1) << BIT_POR;

  logic [CNT_W-1:0] phaseCnt;
  logic [STS_W-1:0] causeVec;
  logic [STS_W-1:0] stsBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strobe.cntClr) phaseCnt <= '0;
    else                    phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign driveDone = (phaseCnt == CNT_W'(DRIVE_CYCLES - 1));
  assign waitDone  = (phaseCnt == CNT_W'(SAMPLE_DELAY - 1));

  always_comb begin
    causeVec           = '0;
    causeVec[BIT_LVD]  = lvdReq;
    causeVec[BIT_WDOG] = wdogReq;
    causeVec[BIT_OP]   = badOpReq;
    causeVec[BIT_ADDR] = badAddrReq;
  end

  assign stsBase = strobe.stsMerge ? status : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else if (strobe.stsFresh || strobe.stsMerge) begin
      status <= porReq ? POR_ONLY : (stsBase | causeVec);
    end else if (strobe.stsPin) begin
      status[BIT_PIN] <= 1'b1;
    end
  end

endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       pinIn,
  input  logic       driveDone,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       sysRst,
  output logic       pinDrvEn
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      SEQ_IDLE: begin
        if (anyReq || !pinIn) begin
          stateNxt        = SEQ_DRIVE;
          strobe.cntClr   = 1'b1;
          strobe.stsFresh = 1'b1;
        end
      end
      SEQ_DRIVE: begin
        if (anyReq) begin
          strobe.cntClr   = 1'b1;
          strobe.stsMerge = 1'b1;
        end else if (driveDone) begin
          stateNxt      = SEQ_WAIT;
          strobe.cntClr = 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (anyReq) begin
          stateNxt        = SEQ_DRIVE;
          strobe.cntClr   = 1'b1;
          strobe.stsMerge = 1'b1;
        end else if (waitDone) begin
          if (pinIn) begin
            stateNxt = SEQ_IDLE;
          end else begin
            stateNxt      = SEQ_HOLD;
            strobe.stsPin = 1'b1;
          end
        end
      end
      SEQ_HOLD: begin
        if (anyReq) begin
          stateNxt        = SEQ_DRIVE;
          strobe.cntClr   = 1'b1;
          strobe.stsMerge = 1'b1;
        end else if (pinIn) begin
          stateNxt = SEQ_IDLE;
        end
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  assign sysRst   = (state != SEQ_IDLE);
  assign pinDrvEn = (state == SEQ_DRIVE);

endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYCLES = 34,
  parameter int SAMPLE_DELAY = 38,
  parameter int STS_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porReq,
  input  logic             lvdReq,
  input  logic             wdogReq,
  input  logic             badOpReq,
  input  logic             badAddrReq,
  input  logic             dbgReq,
  input  logic             pinIn,
  output logic             sysRst,
  output logic             pinDrvEn,
  output logic [STS_W-1:0] status
);

  seqStrobe_t strobe;
  logic       driveDone;
  logic       waitDone;
  logic       anyReq;

  assign anyReq = porReq | lvdReq | wdogReq | badOpReq | badAddrReq | dbgReq;

  rstseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .pinIn     (pinIn),
    .driveDone (driveDone),
    .waitDone  (waitDone),
    .strobe    (strobe),
    .sysRst    (sysRst),
    .pinDrvEn  (pinDrvEn)
  );

  rstseq_datapath #(
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .SAMPLE_DELAY (SAMPLE_DELAY),
    .STS_W        (STS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .porReq     (porReq),
    .lvdReq     (lvdReq),
    .wdogReq    (wdogReq),
    .badOpReq   (badOpReq),
    .badAddrReq (badAddrReq),
    .driveDone  (driveDone),
    .waitDone   (waitDone),
    .status     (status)
  );

endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk #(
  parameter int DRIVE_CYCLES = 34,
  parameter int STS_W        = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             anyReq,
  input logic             porReq,
  input logic             wdogReq,
  input logic             pinIn,
  input logic             sysRst,
  input logic             pinDrvEn,
  input logic [STS_W-1:0] status
);

  logic [15:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    runCnt <= '0;
    else if (pinDrvEn && !anyReq) runCnt <= runCnt + 16'd1;
    else                          runCnt <= '0;
  end

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sysRst && (anyReq || !pinIn)) |=> (sysRst && pinDrvEn));

  // R2
  drive_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinDrvEn |-> (runCnt < 16'(DRIVE_CYCLES)));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinDrvEn) |-> sysRst);

  // R4
  exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRst) |-> $past(pinIn));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[STS_W-1:6] == '0);

  // R7
  por_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> (status == STS_W'(2)));

  // R8
  merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdogReq && !porReq) |=> status[3]);

endmodule

bind rstseq_top rstseq_chk #(
  .DRIVE_CYCLES (DRIVE_CYCLES),
  .STS_W        (STS_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .anyReq   (anyReq),
  .porReq   (porReq),
  .wdogReq  (wdogReq),
  .pinIn    (pinIn),
  .sysRst   (sysRst),
  .pinDrvEn (pinDrvEn),
  .status   (status)
);

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] reqDrive = '0;   // {dbg, badAddr, badOp, wdog, lvd, por}
  logic       extLow = 1'b0;
  logic       porReq, lvdReq, wdogReq, badOpReq, badAddrReq, dbgReq;
  logic       pinIn;
  logic       sysRst, pinDrvEn;
  logic [7:0] status;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign {dbgReq, badAddrReq, badOpReq, wdogReq, lvdReq, porReq} = reqDrive;
  assign pinIn = !(pinDrvEn || extLow);  // open-drain line with pullup

  rstseq_top i_rstseq_top (
    .clk        (clk),
    .rstN       (rstN),
    .porReq     (porReq),
    .lvdReq     (lvdReq),
    .wdogReq    (wdogReq),
    .badOpReq   (badOpReq),
    .badAddrReq (badAddrReq),
    .dbgReq     (dbgReq),
    .pinIn      (pinIn),
    .sysRst     (sysRst),
    .pinDrvEn   (pinDrvEn),
    .status     (status)
  );

  typedef struct packed {
    logic [5:0] req;
    logic [5:0] req2;
    logic [7:0] k2;
    logic [7:0] lowLen;
    logic [7:0] expSts;
    logic [7:0] expDrv;
    logic [7:0] expRst;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{6'h02, 6'h00, 8'd0,  8'd0,   8'h04, 8'd34, 8'd72},   // lvd
    '{6'h04, 6'h00, 8'd0,  8'd0,   8'h08, 8'd34, 8'd72},   // watchdog
    '{6'h08, 6'h00, 8'd0,  8'd0,   8'h10, 8'd34, 8'd72},   // illegal opcode
    '{6'h10, 6'h00, 8'd0,  8'd0,   8'h20, 8'd34, 8'd72},   // illegal address
    '{6'h20, 6'h00, 8'd0,  8'd0,   8'h00, 8'd34, 8'd72},   // debug: no bit
    '{6'h01, 6'h00, 8'd0,  8'd0,   8'h02, 8'd34, 8'd72},   // power-on
    '{6'h0C, 6'h00, 8'd0,  8'd0,   8'h18, 8'd34, 8'd72},   // two causes
    '{6'h03, 6'h00, 8'd0,  8'd0,   8'h02, 8'd34, 8'd72},   // power-on wins
    '{6'h00, 6'h00, 8'd0,  8'd3,   8'h00, 8'd34, 8'd72},   // short line pulse
    '{6'h00, 6'h00, 8'd0,  8'd100, 8'h01, 8'd34, 8'd100},  // line held low
    '{6'h02, 6'h04, 8'd20, 8'd0,   8'h0C, 8'd54, 8'd92},   // restart in drive
    '{6'h02, 6'h10, 8'd50, 8'd0,   8'h24, 8'd68, 8'd122},  // restart in wait
    '{6'h02, 6'h01, 8'd10, 8'd0,   8'h02, 8'd44, 8'd82},   // power-on mid-sequence
    '{6'h00, 6'h08, 8'd80, 8'd100, 8'h11, 8'd68, 8'd152}   // restart in hold
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  initial begin
    #4_000_000;
    failCnt++;
    $display("FAIL R3 watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int drvCnt;
    int rstCnt;
    bit firstOk;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(sysRst == 1'b0 && pinDrvEn == 1'b0, "R9 outputs in reset", {sysRst, pinDrvEn}, 0);
    check(status == 8'h00, "R9 status in reset", status, 0);
    rstN = 1'b1;

    // R1: idle with no request stays out of reset
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sysRst || pinDrvEn) seen = 1'b1;
      end
      check(!seen, "R1 idle without request", seen, 0);
    end

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      reqDrive = VECS[v].req;
      extLow   = (VECS[v].lowLen != 0);
      drvCnt   = 0;
      rstCnt   = 0;
      firstOk  = 1'b0;
      for (int k = 1; k <= 220; k++) begin
        @(negedge clk);
        if (k == 1) firstOk = sysRst && pinDrvEn;
        if (pinDrvEn) drvCnt++;
        if (sysRst) rstCnt++;
        if (k == 1) reqDrive = '0;
        if (VECS[v].k2 != 0 && k == int'(VECS[v].k2)) reqDrive = VECS[v].req2;
        if (VECS[v].k2 != 0 && k == int'(VECS[v].k2) + 1) reqDrive = '0;
        if (k == int'(VECS[v].lowLen)) extLow = 1'b0;
      end
      check(firstOk, $sformatf("R1 vec%0d start next cycle", v), firstOk, 1);
      check(drvCnt == int'(VECS[v].expDrv), $sformatf("R2/R8 vec%0d drive length", v),
            drvCnt, VECS[v].expDrv);
      check(rstCnt == int'(VECS[v].expRst), $sformatf("R3/R4 vec%0d reset length", v),
            rstCnt, VECS[v].expRst);
      check(status == VECS[v].expSts, $sformatf("R5/R6/R7 vec%0d status", v),
            status, VECS[v].expSts);
    end

    // R9: status holds while idle
    repeat (40) @(negedge clk);
    check(status == 8'h11, "R9 status holds in idle", status, 8'h11);

    // R9: reset mid-sequence clears everything
    @(negedge clk);
    reqDrive = 6'h04;
    @(negedge clk);
    reqDrive = '0;
    repeat (10) @(negedge clk);
    check(sysRst == 1'b1, "R1 sequence running before reset", sysRst, 1);
    rstN = 1'b0;
    @(negedge clk);
    check(sysRst == 1'b0 && pinDrvEn == 1'b0, "R9 outputs cleared by rstN", {sysRst, pinDrvEn}, 0);
    check(status == 8'h00, "R9 status cleared by rstN", status, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sysRst == 1'b0, "R9 idle after rstN", sysRst, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule